// File: doc/BRIEF.md
# Multifunction Registered Bus Transceiver

This block holds one W-bit register (eight bits by default) between two data buses, A and B. A three-bit mode code picks one of eight operations that take effect on the rising clock edge: add A to the register with or without a carry-in, count up with or without an enable, shift left one place, load from A, load from B, or hold. One control input is reused for each mode: it is the carry-in, the count enable or the serial input. One status output is reused the same way: it shows the adder carry, terminal count, the bit leaving the shift chain, or the register parity.

Each bus is split into an input, an output and a drive-enable flag. Each bus has its own active-low output enable. An enabled bus is driven with the register value. The value the register sees on that bus is then its own contents, so loading from a bus that is driven reloads the register with itself. The enables change only what the buses show; the register keeps working whatever they are set to. An active-low clear resets the register at once, with no clock edge needed, and forces the status output low.

Top module: `mbx_xcvr`

## Requirements
- R1: While `rst_n` is low, the register is zero and `status` is 0. This holds at once, with no clock edge, and whatever the mode and data inputs are.
- R2: With mode 0, a clock edge stores (A + Q + ctl_in) mod 2^W. Before that edge, `status` already shows the carry out of the same sum.
- R3: With mode 1, a clock edge stores (A + Q) mod 2^W. `status` shows the carry out of that sum, without combinational delay through the register.
- R4: With mode 2, the register increments when `ctl_in` is 1 and holds when it is 0. `status` is 1 only when the register is all ones.
- R5: With mode 3, the register increments on every edge and `ctl_in` has no effect. All ones wraps to zero. `status` is terminal count, as in R4.
- R6: With mode 4, `ctl_in` moves into bit 0 and every bit moves up one place. `status` shows the current top bit.
- R7: Mode 5 loads from bus A and mode 6 loads from bus B. In both modes `status` is 1 when the register holds an odd number of ones.
- R8: With mode 7, the register keeps its value whatever `ctl_in` is. `status` is parity, as in R7.
- R9: `a_out` and `b_out` always carry the register value. `a_drv` is the inverse of `a_oe_n` and `b_drv` is the inverse of `b_oe_n`. The enables never change the register's next value except through the bus value they select (R10).
- R10: When a bus output is enabled, the register sees its own value on that bus and ignores the external input. A load from an enabled bus therefore leaves the register unchanged.
- R11: Adds take their operand only from bus A. The value on bus B has no effect in modes 0 and 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low clear, asynchronous |
| mode | input | 3 | Operation code 0..7 |
| ctl_in | input | 1 | Carry-in, count enable or serial input, depending on mode |
| a_in | input | W | Value driven onto bus A from outside |
| a_oe_n | input | 1 | Active-low enable for driving bus A |
| a_out | output | W | Register value presented to bus A |
| a_drv | output | 1 | High when the block drives bus A |
| b_in | input | W | Value driven onto bus B from outside |
| b_oe_n | input | 1 | Active-low enable for driving bus B |
| b_out | output | W | Register value presented to bus B |
| b_drv | output | 1 | High when the block drives bus B |
| status | output | 1 | Carry, terminal count, serial out or parity |

## Verification
Two things can happen in the same cycle. One is the combinational carry, which leads the sum it belongs to by one clock. The other is the register update that stores that sum. The bench sets up adds whose carry is 1: it checks `status` before the edge, against the carry computed from the register and the inputs, and it checks the truncated sum on the bus after the edge. A second pair that can coincide is a load and the bus enable. The bench loads from a bus whose output is enabled while a different value sits on the external input, and it expects the register to keep its value.

// File: rtl/mbx_xcvr_pkg.sv
// Package: shared mode encoding for the multifunction transceiver.
// Assumes the three-bit mode code is decoded exactly as listed below.
package mbx_xcvr_pkg;

    typedef enum logic [2:0] {
        MD_ADD_CI    = 3'd0,
        MD_ADD       = 3'd1,
        MD_CNT_GATED = 3'd2,
        MD_CNT_FREE  = 3'd3,
        MD_SHIFT     = 3'd4,
        MD_LOAD_A    = 3'd5,
        MD_LOAD_B    = 3'd6,
        MD_HOLD      = 3'd7
    } xcvr_mode_e;

endpackage

// File: rtl/mbx_xcvr_next.sv
// Module: next-state logic for the register.
// Works out the value to store at the next edge, and the adder carry, from
// the current register, the effective bus values, the mode and the control
// input. Purely combinational; the caller holds the register.
module mbx_xcvr_next
    import mbx_xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] q,
    input  logic [W-1:0] a_eff,
    input  logic [W-1:0] b_eff,
    input  xcvr_mode_e   md,
    input  logic         ctl,
    output logic [W-1:0] q_nxt,
    output logic         carry
);

    localparam int SW = W + 1;

    logic [SW-1:0] sum;
    logic          cin;

    // Adder: bus A plus register, with the carry-in used only in mode 0.
    always_comb begin
        cin   = (md == MD_ADD_CI) && ctl;
        sum   = {1'b0, a_eff} + {1'b0, q} + {{W{1'b0}}, cin};
        carry = sum[SW-1];
    end

    // Mode decode: choose the value to store at the next edge.
    always_comb begin
        unique case (md)
            MD_ADD_CI, MD_ADD: q_nxt = sum[W-1:0];
            MD_CNT_GATED:      q_nxt = ctl ? q + {{(W-1){1'b0}}, 1'b1} : q;
            MD_CNT_FREE:       q_nxt = q + {{(W-1){1'b0}}, 1'b1};
            MD_SHIFT:          q_nxt = {q[W-2:0], ctl};
            MD_LOAD_A:         q_nxt = a_eff;
            MD_LOAD_B:         q_nxt = b_eff;
            default:           q_nxt = q;
        endcase
    end

endmodule

// File: rtl/mbx_xcvr_status.sv
// Module: status output multiplexer.
// Picks carry, terminal count, serial out or parity, depending on the mode.
// Forced low while clear is active. Assumes W >= 2.
module mbx_xcvr_status
    import mbx_xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         rst_n,
    input  xcvr_mode_e   md,
    input  logic [W-1:0] q,
    input  logic         carry,
    output logic         status
);

    logic [W-1:0] par_chain;
    logic         term_cnt;

    // Parity: XOR chain over the register bits, built one stage per bit.
    assign par_chain[0] = q[0];
    for (genvar i = 1; i < W; i++) begin : g_par
        assign par_chain[i] = par_chain[i-1] ^ q[i];
    end

    // Terminal count: all register bits set.
    assign term_cnt = &q;

    // Status select, with clear overriding every mode.
    always_comb begin
        if (!rst_n) begin
            status = 1'b0;
        end else begin
            unique case (md)
                MD_ADD_CI, MD_ADD:        status = carry;
                MD_CNT_GATED, MD_CNT_FREE: status = term_cnt;
                MD_SHIFT:                 status = q[W-1];
                default:                  status = par_chain[W-1];
            endcase
        end
    end

endmodule

// File: rtl/mbx_xcvr.sv
// Module: multifunction registered bus transceiver, top level.
// Holds the W-bit register and works out the effective bus values: an enabled
// bus reads back the register, a disabled bus reads the external input. The
// register is cleared asynchronously by rst_n. Both bus outputs always show
// the register; the drive flags tell the bus fabric when to use them.
module mbx_xcvr
    import mbx_xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   mode,
    input  logic         ctl_in,
    input  logic [W-1:0] a_in,
    input  logic         a_oe_n,
    output logic [W-1:0] a_out,
    output logic         a_drv,
    input  logic [W-1:0] b_in,
    input  logic         b_oe_n,
    output logic [W-1:0] b_out,
    output logic         b_drv
    ,output logic        status
);

    xcvr_mode_e   md;
    logic [W-1:0] q;
    logic [W-1:0] q_nxt;
    logic [W-1:0] a_eff;
    logic [W-1:0] b_eff;
    logic         carry;

    // Mode code cast to the shared enum.
    assign md = xcvr_mode_e'(mode);

    // Effective bus values: a driven bus reads back the register.
    assign a_eff = a_oe_n ? a_in : q;
    assign b_eff = b_oe_n ? b_in : q;

    // Bus outputs and drive flags.
    assign a_out = q;
    assign b_out = q;
    assign a_drv = ~a_oe_n;
    assign b_drv = ~b_oe_n;

    mbx_xcvr_next #(.W(W)) i_next (
        .q     (q),
        .a_eff (a_eff),
        .b_eff (b_eff),
        .md    (md),
        .ctl   (ctl_in),
        .q_nxt (q_nxt),
        .carry (carry)
    );

    mbx_xcvr_status #(.W(W)) i_status (
        .rst_n  (rst_n),
        .md     (md),
        .q      (q),
        .carry  (carry),
        .status (status)
    );

    // Register: cleared at once by rst_n, otherwise loaded each edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_nxt;
    end

endmodule

// File: rtl/mbx_xcvr_chk.sv
// Module: assertion checker for mbx_xcvr, attached with bind below.
// Looks only at top-level ports and rebuilds the effective A value from them.
module mbx_xcvr_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [2:0]   mode,
    input logic         ctl_in,
    input logic [W-1:0] a_in,
    input logic         a_oe_n,
    input logic [W-1:0] a_out,
    input logic         status
);

    logic [W-1:0] a_seen;
    logic [W:0]   sum_ci;
    logic [W:0]   sum_nc;

    // Reference sums from port values, used one cycle later.
    always_comb begin
        a_seen = a_oe_n ? a_in : a_out;
        sum_ci = {1'b0, a_seen} + {1'b0, a_out} + {{W{1'b0}}, ctl_in};
        sum_nc = {1'b0, a_seen} + {1'b0, a_out};
    end

    p_clear_status_r1: assert property (@(posedge clk)
        !rst_n |-> (status == 1'b0));

    p_add_carry_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0) |=> ({$past(status), a_out} == $past(sum_ci)));

    p_add_plain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd1) |=> ({$past(status), a_out} == $past(sum_nc)));

    p_gated_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd2 && !ctl_in) |=> $stable(a_out));

    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3 && status) |=> (a_out == '0));

    p_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4) |=> (a_out == {$past(a_out[W-2:0]), $past(ctl_in)}));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd7) |=> $stable(a_out));

    p_self_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd5 && !a_oe_n) |=> $stable(a_out));

endmodule

bind mbx_xcvr mbx_xcvr_chk #(.W(W)) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode),
    .ctl_in (ctl_in),
    .a_in   (a_in),
    .a_oe_n (a_oe_n),
    .a_out  (a_out),
    .status (status)
);

// File: tb/test_mbx_xcvr.sv
// Bench for mbx_xcvr: a vector table walked by one loop against a reference
// model, then directed tests for clear, self-reload, the A-only adder and
// the drive flags.
module test_mbx_xcvr;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = 3'd7;
    logic       ctl_in = 1'b0;
    logic [7:0] a_in = 8'h00;
    logic [7:0] b_in = 8'h00;
    logic       a_oe_n = 1'b1;
    logic       b_oe_n = 1'b1;
    logic [7:0] a_out, b_out;
    logic       a_drv, b_drv, status;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] mq = 8'h00;

    always #10 clk = ~clk;

    mbx_xcvr #(.W(8)) i_mbx_xcvr (
        .clk(clk), .rst_n(rst_n), .mode(mode), .ctl_in(ctl_in),
        .a_in(a_in), .a_oe_n(a_oe_n), .a_out(a_out), .a_drv(a_drv),
        .b_in(b_in), .b_oe_n(b_oe_n), .b_out(b_out), .b_drv(b_drv),
        .status(status)
    );

    // Vector fields: mode[21:19] ctl[18] a[17:10] b[9:2] a_oe_n[1] b_oe_n[0]
    localparam logic [21:0] VEC [0:16] = '{
        {3'd5, 1'b0, 8'h5A, 8'h00, 1'b1, 1'b1},  // load A
        {3'd5, 1'b1, 8'h00, 8'h00, 1'b0, 1'b1},  // load A while A driven: R10
        {3'd6, 1'b0, 8'h00, 8'hC3, 1'b1, 1'b1},  // load B
        {3'd6, 1'b0, 8'h00, 8'h11, 1'b1, 1'b0},  // load B while B driven
        {3'd7, 1'b1, 8'hFF, 8'hFF, 1'b1, 1'b1},  // hold, ctl ignored
        {3'd0, 1'b1, 8'h3D, 8'h00, 1'b1, 1'b1},  // add with carry, overflow
        {3'd1, 1'b1, 8'h10, 8'hFF, 1'b1, 1'b1},  // add without carry
        {3'd1, 1'b0, 8'hAA, 8'h00, 1'b0, 1'b1},  // add with A driven
        {3'd4, 1'b1, 8'h00, 8'h00, 1'b1, 1'b1},  // shift in 1
        {3'd4, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1},  // shift in 0
        {3'd4, 1'b1, 8'h00, 8'h00, 1'b1, 1'b1},  // shift, top bit out
        {3'd5, 1'b0, 8'hFE, 8'h00, 1'b1, 1'b0},  // load A
        {3'd2, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1},  // gated count, hold
        {3'd2, 1'b1, 8'h00, 8'h00, 1'b1, 1'b1},  // gated count, step
        {3'd3, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1},  // free count, wrap
        {3'd3, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0},  // free count
        {3'd0, 1'b1, 8'hFF, 8'h00, 1'b1, 1'b1}   // add with carry, overflow
    };

    function automatic string req_of(input logic [2:0] m);
        case (m)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd7: return "R8";
            default: return "R7";
        endcase
    endfunction

    // Reference model: returns {status, next register value}.
    function automatic logic [8:0] ref_eval(input logic [2:0] m, input logic c,
                                            input logic [7:0] q, input logic [7:0] ae,
                                            input logic [7:0] be);
        logic [8:0] s;
        case (m)
            3'd0: begin s = {1'b0, ae} + {1'b0, q} + {8'd0, c}; return s; end
            3'd1: begin s = {1'b0, ae} + {1'b0, q}; return s; end
            3'd2: return {(q == 8'hFF), (c ? q + 8'd1 : q)};
            3'd3: return {(q == 8'hFF), q + 8'd1};
            3'd4: return {q[7], q[6:0], c};
            3'd5: return {^q, ae};
            3'd6: return {^q, be};
            default: return {^q, q};
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // One vector: drive at the falling edge, check, then advance the model.
    task automatic apply(input logic [21:0] v);
        logic [8:0] r;
        logic [7:0] ae, be;
        @(negedge clk);
        {mode, ctl_in, a_in, b_in, a_oe_n, b_oe_n} = v;
        #2;
        ae = a_oe_n ? a_in : mq;
        be = b_oe_n ? b_in : mq;
        r = ref_eval(mode, ctl_in, mq, ae, be);
        check(req_of(mode), "register", a_out, mq);
        check(req_of(mode), "status", {7'd0, status}, {7'd0, r[8]});
        @(posedge clk);
        mq = r[7:0];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state.
        #5;
        check("R1", "reset register", a_out, 8'h00);
        check("R1", "reset status", {7'd0, status}, 8'h00);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        foreach (VEC[i]) apply(VEC[i]);
        @(negedge clk);
        #2;
        check(req_of(mode), "final register", a_out, mq);

        // R10: load from driven A; the external value 0x00 must be ignored.
        apply({3'd5, 1'b0, 8'h3C, 8'h00, 1'b1, 1'b1});
        apply({3'd5, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1});
        @(negedge clk);
        #2;
        check("R10", "self reload A", a_out, 8'h3C);
        apply({3'd6, 1'b0, 8'h00, 8'h99, 1'b1, 1'b0});
        @(negedge clk);
        #2;
        check("R10", "self reload B", a_out, 8'h3C);

        // R11: bus B value has no effect on an add.
        apply({3'd1, 1'b0, 8'h01, 8'hFF, 1'b1, 1'b1});
        @(negedge clk);
        #2;
        check("R11", "add ignores B", a_out, 8'h3D);

        // R9: both outputs show the register; drive flags follow enables.
        mode = 3'd7; a_oe_n = 1'b0; b_oe_n = 1'b1;
        #2;
        check("R9", "b_out mirror", b_out, a_out);
        check("R9", "drive flags", {6'd0, a_drv, b_drv}, 8'b10);
        a_oe_n = 1'b1; b_oe_n = 1'b0;
        #2;
        check("R9", "drive flags swapped", {6'd0, a_drv, b_drv}, 8'b01);

        // R1: clear between edges, with a mode whose status would be 1.
        mode = 3'd0; a_in = 8'hFF; a_oe_n = 1'b1; ctl_in = 1'b1;
        #2;
        check("R2", "carry before clear", {7'd0, status}, 8'h01);
        rst_n = 1'b0;
        #1;
        check("R1", "async clear register", a_out, 8'h00);
        check("R1", "async clear status", {7'd0, status}, 8'h00);
        @(posedge clk);
        #2;
        check("R1", "held in clear", a_out, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        mq = 8'h00;
        apply({3'd3, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1});
        @(negedge clk);
        #2;
        check("R5", "count after clear", a_out, 8'h01);

        finish_run();
    end

endmodule